// File: doc/BRIEF.md
# Parallel Link Direction Turnaround Controller

This block reverses the data direction of a parallel peripheral link that runs in extended-capability mode. The host asks it for a reverse turnaround (the peripheral will send) or a forward turnaround (the host will send). It then sequences the host-side control lines and waits for the peripheral's acknowledge on its paper-error status line. A reverse turnaround first asserts the autofeed line. After a short settle delay it drives nInit low, and it then waits for the peripheral to pull the status line low. A forward turnaround releases autofeed and drives nInit high, then waits for the status line to return high.

Each acknowledge wait is bounded by a window of roughly 35 ms. When that window runs out, the status line is sampled once more before the turnaround is declared failed. A success moves the reported link phase to reverse-idle or forward-idle and gives a one-cycle done pulse. A failure moves the phase to unknown, gives an error pulse and, when enabled, drives a fixed-length bus-reset pulse. Every exit path, success or failure, hands back the extended-mode value that was captured when the turnaround was accepted, together with a restore strobe. Both the settle delay and the window are derived from a clock-frequency parameter.

Top module: `ecp_turnaround`

## Requirements
- R1: In the idle state, with the phase not reverse-idle, a `req_rev` high at a clock edge sets `autofeed_o` and `busy_o` to 1 from that edge on.
- R2: `ninit_o` falls exactly SETTLE_CYC clock edges after the edge that accepted a reverse request (SETTLE_CYC = CLK_HZ*SETTLE_NS/1e9, at least 1). `autofeed_o` stays at 1 over that interval.
- R3: `perr_in` passes through a two-flop synchronizer. In a reverse wait, a synchronized low ends the turnaround: `done_o` pulses for one cycle, `busy_o` drops and `phase_o` becomes reverse-idle.
- R4: In the idle state, with the phase not forward-idle, a `req_fwd` sets `ninit_o` to 1 and `autofeed_o` to 0 at the accepting edge. A synchronized high on `perr_in` then ends the turnaround with `done_o` and `phase_o` forward-idle.
- R5: The acknowledge window lasts WAIT_CYC cycles (CLK_HZ/1e6*WAIT_US). One extra recheck cycle follows it, and a level seen in that recheck cycle still counts as success.
- R6: When the recheck also fails, `err_o` pulses for one cycle and `phase_o` becomes unknown. `ninit_o` and `autofeed_o` keep their levels, and `done_o` never pulses in the same cycle as `err_o`.
- R7: `phase_o` is encoded 2'b00 forward-idle, 2'b01 reverse-idle, 2'b10 unknown. It changes only in a cycle where `done_o` or `err_o` is high.
- R8: With BUS_RESET_EN set, a failure raises `bus_rst_o` for exactly BUSRST_CYC cycles, starting in the cycle of `err_o`. `busy_o` stays high until the pulse ends, and `bus_rst_o` is never high while `busy_o` is low.
- R9: The accepting edge captures `ext_mode_i`. On every exit, `ext_restore_o` pulses together with `done_o` or `err_o`, and `ext_mode_o` shows the captured value. `ext_mode_o` never changes at any other time.
- R10: A request that arrives while `busy_o` is high, or that asks for the phase already in effect, has no effect on `phase_o`, `ninit_o`, `autofeed_o` or `busy_o`.
- R11: After a synchronous reset, the outputs are: `phase_o` forward-idle, `ninit_o` 1, `autofeed_o` 0, `busy_o` 0, and every pulse output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rev | input | 1 | Request a turnaround to reverse |
| req_fwd | input | 1 | Request a turnaround to forward |
| perr_in | input | 1 | Peripheral paper-error status line, asynchronous |
| ext_mode_i | input | EXT_W | Extended-mode register value to save |
| autofeed_o | output | 1 | Autofeed (host acknowledge) asserted |
| ninit_o | output | 1 | nInit line level |
| busy_o | output | 1 | Turnaround in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| bus_rst_o | output | 1 | Bus-reset pulse after a failure |
| phase_o | output | 2 | Link phase: 00 forward-idle, 01 reverse-idle, 10 unknown |
| ext_restore_o | output | 1 | Strobe to write `ext_mode_o` back |
| ext_mode_o | output | EXT_W | Saved extended-mode value for the restore |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check is relied upon. They also assume that `perr_in` may change at any time, because only the synchronized copy is ever used. They make no assumption about how requests are spaced, since ignoring requests at the wrong time is itself a requirement. The stimulus drives every input on the falling clock edge. It places `perr_in` transitions at cycle counts worked out from the request edge, which is how the last-cycle recheck and the one-cycle-late failure are both reached.

// File: rtl/ecp_turnaround_pkg.sv
package ecp_turnaround_pkg;
  typedef enum logic [1:0] {
    PH_FWD = 2'b00,
    PH_REV = 2'b01,
    PH_UNK = 2'b10
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT,
    ST_RECHECK,
    ST_BUSRST
  } tat_state_t;
endpackage

// File: rtl/tat_sync.sv
module tat_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= INIT;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tat_timer.sv
module tat_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ecp_turnaround.sv
module ecp_turnaround
  import ecp_turnaround_pkg::*;
#(
  parameter longint CLK_HZ       = 100_000_000,
  parameter int     SETTLE_NS    = 1000,
  parameter int     WAIT_US      = 35_000,
  parameter bit     BUS_RESET_EN = 1'b1,
  parameter int     BUSRST_CYC   = 16,
  parameter int     SYNC_STAGES  = 2,
  parameter int     EXT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_rev,
  input  logic             req_fwd,
  input  logic             perr_in,
  input  logic [EXT_W-1:0] ext_mode_i,
  output logic             autofeed_o,
  output logic             ninit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             bus_rst_o,
  output logic [1:0]       phase_o,
  output logic             ext_restore_o,
  output logic [EXT_W-1:0] ext_mode_o
);
  localparam longint SETTLE_RAW = (CLK_HZ * SETTLE_NS) / 64'd1_000_000_000;
  localparam longint SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam longint WAIT_RAW   = (CLK_HZ / 64'd1_000_000) * WAIT_US;
  localparam longint WAIT_CYC   = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam longint BR_CYC     = (BUSRST_CYC < 1) ? 1 : BUSRST_CYC;
  localparam longint MAX_A      = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
  localparam longint MAX_CYC    = (MAX_A > BR_CYC) ? MAX_A : BR_CYC;
  localparam int     CNT_W      = $clog2(MAX_CYC + 1);

  tat_state_t       st;
  phase_t           phase;
  logic             dir_rev;
  logic [EXT_W-1:0] saved;
  logic             perr_s;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             acc_rev, acc_fwd, level_ok, ok_now, fail_now;

  tat_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(perr_in), .q(perr_s)
  );

  tat_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    acc_rev  = (st == ST_IDLE) && req_rev && (phase != PH_REV);
    acc_fwd  = (st == ST_IDLE) && !acc_rev && req_fwd && (phase != PH_FWD);
    level_ok = (perr_s == !dir_rev);
    ok_now   = ((st == ST_WAIT) || (st == ST_RECHECK)) && level_ok;
    fail_now = (st == ST_RECHECK) && !level_ok;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (acc_rev) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(SETTLE_CYC - 1);
    end else if (acc_fwd || ((st == ST_SETTLE) && tmr_zero)) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(WAIT_CYC - 1);
    end else if (fail_now) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(BR_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      phase         <= PH_FWD;
      dir_rev       <= 1'b0;
      saved         <= '0;
      autofeed_o    <= 1'b0;
      ninit_o       <= 1'b1;
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
      bus_rst_o     <= 1'b0;
      ext_restore_o <= 1'b0;
      ext_mode_o    <= '0;
    end else begin
      done_o        <= 1'b0;
      err_o         <= 1'b0;
      ext_restore_o <= 1'b0;
      if (acc_rev) begin
        st         <= ST_SETTLE;
        dir_rev    <= 1'b1;
        autofeed_o <= 1'b1;
        busy_o     <= 1'b1;
        saved      <= ext_mode_i;
      end else if (acc_fwd) begin
        st         <= ST_WAIT;
        dir_rev    <= 1'b0;
        autofeed_o <= 1'b0;
        ninit_o    <= 1'b1;
        busy_o     <= 1'b1;
        saved      <= ext_mode_i;
      end
      if ((st == ST_SETTLE) && tmr_zero) begin
        ninit_o <= 1'b0;
        st      <= ST_WAIT;
      end
      if ((st == ST_WAIT) && !level_ok && tmr_zero) st <= ST_RECHECK;
      if (ok_now) begin
        st            <= ST_IDLE;
        busy_o        <= 1'b0;
        done_o        <= 1'b1;
        ext_restore_o <= 1'b1;
        ext_mode_o    <= saved;
        phase         <= dir_rev ? PH_REV : PH_FWD;
      end
      if (fail_now) begin
        err_o         <= 1'b1;
        ext_restore_o <= 1'b1;
        ext_mode_o    <= saved;
        phase         <= PH_UNK;
        if (BUS_RESET_EN) begin
          bus_rst_o <= 1'b1;
          st        <= ST_BUSRST;
        end else begin
          busy_o <= 1'b0;
          st     <= ST_IDLE;
        end
      end
      if ((st == ST_BUSRST) && tmr_zero) begin
        bus_rst_o <= 1'b0;
        busy_o    <= 1'b0;
        st        <= ST_IDLE;
      end
    end
  end

  assign phase_o = phase;
endmodule

// File: rtl/ecp_turnaround_chk.sv
module ecp_turnaround_chk #(
  parameter int EXT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             autofeed_o,
  input logic             ninit_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             bus_rst_o,
  input logic [1:0]       phase_o,
  input logic             ext_restore_o,
  input logic [EXT_W-1:0] ext_mode_o
);
  assert_autofeed_before_ninit_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ninit_o) |-> autofeed_o);

  assert_done_err_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  assert_rev_done_ninit_low_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && phase_o == 2'b01) |-> !ninit_o);

  assert_fwd_done_ninit_high_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && phase_o == 2'b00) |-> (ninit_o && !autofeed_o));

  assert_phase_moves_on_exit_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_o) |-> (done_o || err_o));

  assert_phase_legal_R7: assert property (@(posedge clk) disable iff (rst)
    phase_o != 2'b11);

  assert_busrst_inside_busy_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rst_o |-> busy_o);

  assert_restore_on_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o || err_o) |-> ext_restore_o);

  assert_ext_only_on_restore_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(ext_mode_o) |-> ext_restore_o);

  assert_exit_drops_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind ecp_turnaround ecp_turnaround_chk #(.EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .autofeed_o(autofeed_o), .ninit_o(ninit_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .bus_rst_o(bus_rst_o),
  .phase_o(phase_o), .ext_restore_o(ext_restore_o), .ext_mode_o(ext_mode_o)
);

// File: tb/ecp_turnaround_test.sv
module ecp_turnaround_test;
  localparam int S  = 5;    // 100 MHz * 50 ns
  localparam int W  = 200;  // 100 cycles/us * 2 us
  localparam int BR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_rev = 1'b0, req_fwd = 1'b0, perr_in = 1'b1;
  logic [7:0] ext_mode_i = 8'h00;
  logic autofeed_o, ninit_o, busy_o, done_o, err_o, bus_rst_o, ext_restore_o;
  logic [1:0] phase_o;
  logic [7:0] ext_mode_o;

  int tests = 0, fails = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  ecp_turnaround #(
    .CLK_HZ(100_000_000), .SETTLE_NS(50), .WAIT_US(2),
    .BUS_RESET_EN(1'b1), .BUSRST_CYC(BR), .SYNC_STAGES(2), .EXT_W(8)
  ) uut (
    .clk(clk), .rst(rst), .req_rev(req_rev), .req_fwd(req_fwd), .perr_in(perr_in),
    .ext_mode_i(ext_mode_i), .autofeed_o(autofeed_o), .ninit_o(ninit_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .bus_rst_o(bus_rst_o),
    .phase_o(phase_o), .ext_restore_o(ext_restore_o), .ext_mode_o(ext_mode_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 settle, 2 wait, 3 recheck, 4 reset pulse
  int  m_mode = 0, m_left = 0;
  bit  m_rev = 0, q1 = 1, q2 = 1;
  logic e_af = 0, e_ni = 1, e_busy = 0, e_done = 0, e_err = 0, e_br = 0, e_rest = 0;
  logic [1:0] e_ph = 2'b00;
  logic [7:0] e_sv = 0, e_ext = 0;

  always @(posedge clk) begin : model
    bit seen, good;
    if (rst) begin
      m_mode = 0; m_left = 0; m_rev = 0; q1 = 1; q2 = 1;
      e_af = 0; e_ni = 1; e_busy = 0; e_done = 0; e_err = 0; e_br = 0; e_rest = 0;
      e_ph = 2'b00; e_sv = 0; e_ext = 0;
    end else begin
      seen = q2; q2 = q1; q1 = perr_in;
      good = (seen == !m_rev);
      e_done = 0; e_err = 0; e_rest = 0;
      if (m_mode == 0) begin
        if (req_rev && e_ph != 2'b01) begin
          m_mode = 1; m_left = S; m_rev = 1; e_af = 1; e_busy = 1; e_sv = ext_mode_i;
        end else if (req_fwd && e_ph != 2'b00) begin
          m_mode = 2; m_left = W; m_rev = 0; e_af = 0; e_ni = 1; e_busy = 1; e_sv = ext_mode_i;
        end
      end else if (m_mode == 1) begin
        m_left--;
        if (m_left == 0) begin m_mode = 2; m_left = W; e_ni = 0; end
      end else if (m_mode == 2 || m_mode == 3) begin
        m_left--;
        if (good) begin
          m_mode = 0; e_busy = 0; e_done = 1; e_rest = 1; e_ext = e_sv;
          e_ph = m_rev ? 2'b01 : 2'b00;
        end else if (m_mode == 3) begin
          m_mode = 4; m_left = BR; e_err = 1; e_rest = 1; e_ext = e_sv; e_ph = 2'b10; e_br = 1;
        end else if (m_left == 0) m_mode = 3;
      end else begin
        m_left--;
        if (m_left == 0) begin m_mode = 0; e_br = 0; e_busy = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      check("R1 autofeed", autofeed_o, e_af);
      check("R2 ninit", ninit_o, e_ni);
      check("R10 busy", busy_o, e_busy);
      check("R3 done", done_o, e_done);
      check("R6 err", err_o, e_err);
      check("R8 bus_rst", bus_rst_o, e_br);
      check("R7 phase", phase_o, e_ph);
      check("R9 restore", ext_restore_o, e_rest);
      check("R9 ext_mode", ext_mode_o, e_ext);
    end
  end

  int n_done, n_err, n_br;
  task automatic wait_idle();
    n_done = 0; n_err = 0; n_br = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n_done += done_o; n_err += err_o; n_br += bus_rst_o;
      if (!busy_o) break;
    end
  endtask

  task automatic pulse(input bit rev);
    if (rev) req_rev = 1'b1; else req_fwd = 1'b1;
    @(negedge clk);
    req_rev = 1'b0; req_fwd = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0; running = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 phase", phase_o, 2'b00);
    check("R11 ninit", ninit_o, 1);
    check("R11 autofeed", autofeed_o, 0);
    check("R11 busy", busy_o, 0);
    // R10 forward request while forward-idle
    pulse(0); repeat (3) @(negedge clk);
    check("R10 same-dir busy", busy_o, 0);
    check("R10 same-dir ninit", ninit_o, 1);
    // R1/R2/R3 reverse success
    ext_mode_i = 8'hA5;
    pulse(1);
    check("R1 autofeed up", autofeed_o, 1);
    check("R1 busy up", busy_o, 1);
    ext_mode_i = 8'h3C;
    repeat (S-1) @(negedge clk);
    check("R2 ninit before settle", ninit_o, 1);
    @(negedge clk);
    check("R2 ninit after settle", ninit_o, 0);
    repeat (20) @(negedge clk);
    perr_in = 1'b0;
    wait_idle();
    check("R3 done seen", n_done, 1);
    check("R3 phase rev", phase_o, 2'b01);
    check("R9 ext restored", ext_mode_o, 8'hA5);
    // R10 reverse request while reverse-idle
    pulse(1); repeat (3) @(negedge clk);
    check("R10 rev-idle busy", busy_o, 0);
    check("R10 rev-idle autofeed", autofeed_o, 1);
    // R4 forward success, with a reverse request while busy
    pulse(0);
    check("R4 ninit high", ninit_o, 1);
    check("R4 autofeed low", autofeed_o, 0);
    pulse(1); @(negedge clk);
    check("R10 busy request autofeed", autofeed_o, 0);
    repeat (10) @(negedge clk);
    perr_in = 1'b1;
    wait_idle();
    check("R4 phase fwd", phase_o, 2'b00);
    // R6/R8 reverse timeout
    ext_mode_i = 8'h5A;
    pulse(1);
    wait_idle();
    check("R6 err seen", n_err, 1);
    check("R6 no done", n_done, 0);
    check("R6 phase unknown", phase_o, 2'b10);
    check("R6 ninit kept low", ninit_o, 0);
    check("R8 reset length", n_br, BR);
    check("R9 ext after fail", ext_mode_o, 8'h5A);
    // R5 reverse success on the recheck cycle
    pulse(1);
    repeat (S+W-2) @(negedge clk);
    perr_in = 1'b0;
    wait_idle();
    check("R5 recheck success", n_done, 1);
    check("R5 recheck no err", n_err, 0);
    check("R5 phase rev", phase_o, 2'b01);
    // R5 forward acknowledge one cycle too late
    pulse(0);
    repeat (W-1) @(negedge clk);
    perr_in = 1'b1;
    wait_idle();
    check("R5 late err", n_err, 1);
    check("R5 late phase", phase_o, 2'b10);
    // R4 forward from unknown with line already high
    pulse(0);
    wait_idle();
    check("R4 unknown->fwd", phase_o, 2'b00);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule